// File: doc/BRIEF.md
# Serial Flash to Memory DMA Reader

This block copies a contiguous range of serial NOR flash into system memory. Software fills in a flash source address, a destination start address and a destination end address, selects the read mode, and then sets a start bit. The engine drives a mode-0 serial flash port. It sends the read opcode, then the address, then any dummy clocks, and then clocks the data in over one, two or four data lines.

Incoming bytes are gathered into 16-byte lines. Each line leaves on a valid/ready write-request port as a single aligned beat. When a full line is waiting behind a write that has not yet been accepted, the engine stops the flash clock. This means no byte is ever dropped. When the last line has been accepted and chip select is high again, the engine clears the start bit, which software polls.

Top module: `nor_dma_reader`

## Requirements
- R1: After reset every register reads 0, chip select is high, the flash clock is low and no write request is valid.
- R2: Registers are selected by a 3-bit word index: 0 control (bit 0 start), 1 flash source, 2 destination start, 3 destination end, 4 bus mode (bit 0 dual data, bit 1 dual address, bit 2 quad data, bit 3 quad address, bit 4 four-byte address), 5 read options (bit 0 fast read), 6 dual-read opcode (bits 7:0), 7 quad-read opcode (bits 7:0). Written values read back, with unused bits reading 0.
- R3: The opcode is always sent MSB first on line 0, in mode 0: outputs change while the clock is low and are sampled on its rising edge. In single mode the input byte arrives MSB first on line 1. With fast read clear the opcode is 0x03 and there are no dummy clocks. With fast read set the opcode is 0x0B, followed by 8 dummy clocks.
- R4: The address is sent MSB first, with the source's low 4 bits forced to zero. It is 24 bits (the source's low 24 bits) unless the four-byte bit is set, in which case it is 32 bits.
- R5: With dual data set and quad data clear, the opcode comes from register 6. The address goes out on lines 1:0 when dual address is set, otherwise on line 0. Eight dummy clocks follow the address. Data arrives two bits per clock as {line1,line0}, MSB pair first.
- R6: Quad data has priority over dual data. The opcode then comes from register 7. The address goes out on lines 3:0 when quad address is set. Eight dummy clocks follow. Data arrives four bits per clock on lines 3:0, high nibble first.
- R7: The transfer length is destination end minus destination start, with its low 4 bits dropped. Each 16-byte line becomes one write request. Its address is the aligned destination start plus 16 per line, and the flash byte at offset j within the line sits in data bits 8j+7:8j.
- R8: A write request holds its address and data unchanged until it is accepted. While a completed line is waiting behind an unaccepted request, the flash clock stops and no data is lost.
- R9: The start bit clears only after the last write has been accepted and chip select has risen. A transfer of length 0 clears it without selecting the flash or issuing a write.
- R10: While the start bit is set, register writes (including writes to control) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| spi_sclk | output | 1 | Flash serial clock |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_io_out | output | 4 | Flash data lines, outgoing |
| spi_io_oe | output | 4 | Output enable per flash data line |
| spi_io_in | input | 4 | Flash data lines, incoming |
| mw_valid | output | 1 | Memory write request valid |
| mw_ready | input | 1 | Memory write request accepted |
| mw_addr | output | 32 | Memory write address, 16-byte aligned |
| mw_data | output | 128 | Memory write data, one line |

## Verification
Faults in the serial sequencer show up at the flash port within the first clocks of a transfer:
- A wrong phase counter or lane setting shifts the captured opcode or address.
- It also shifts every returned byte, so the first written line is corrupted.

Faults in line assembly show up on the first accepted write, as a misplaced byte or a misaligned address.

A broken stall or completion path shows within a few hundred cycles in either of two ways:
- a clock that keeps running while memory is held off, followed by a missing or corrupt line;
- a start bit that falls while a write is still pending.

// File: rtl/nordma_pkg.sv
// Shared types and register indices for the flash-to-memory DMA reader.
package nordma_pkg;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 3;

    // Lane encoding doubles as the log2 of the line count.
    typedef enum logic [1:0] {LN_1 = 2'd0, LN_2 = 2'd1, LN_4 = 2'd2} lane_e;

    localparam logic [IDX_W-1:0] RI_CTRL = 3'd0;
    localparam logic [IDX_W-1:0] RI_SRC  = 3'd1;
    localparam logic [IDX_W-1:0] RI_DST  = 3'd2;
    localparam logic [IDX_W-1:0] RI_END  = 3'd3;
    localparam logic [IDX_W-1:0] RI_BUS  = 3'd4;
    localparam logic [IDX_W-1:0] RI_OPT  = 3'd5;
    localparam logic [IDX_W-1:0] RI_OPD  = 3'd6;
    localparam logic [IDX_W-1:0] RI_OPQ  = 3'd7;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] dst_end;
        logic [4:0]        bus;
        logic              fast;
        logic [7:0]        op_dual;
        logic [7:0]        op_quad;
    } cfg_t;
endpackage

// File: rtl/nordma_regs.sv
// Configuration registers and the start bit.
// Assumes: writes are ignored while the start bit is set; clr_start
// is a one-cycle pulse from the controller that ends a transfer.
module nordma_regs
    import nordma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    input  logic             clr_start,
    output logic [31:0]      rdata,
    output logic             start,
    output cfg_t             cfg
);
    // Register writes, the start bit and its completion clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start <= 1'b0;
            cfg   <= '0;
        end else if (clr_start) begin
            start <= 1'b0;
        end else if (we && !start) begin
            unique case (idx)
                RI_CTRL: start       <= wdata[0];
                RI_SRC:  cfg.src     <= wdata;
                RI_DST:  cfg.dst     <= wdata;
                RI_END:  cfg.dst_end <= wdata;
                RI_BUS:  cfg.bus     <= wdata[4:0];
                RI_OPT:  cfg.fast    <= wdata[0];
                RI_OPD:  cfg.op_dual <= wdata[7:0];
                default: cfg.op_quad <= wdata[7:0];
            endcase
        end
    end

    // Read-back multiplexer.
    always_comb begin
        unique case (idx)
            RI_CTRL: rdata = {31'b0, start};
            RI_SRC:  rdata = cfg.src;
            RI_DST:  rdata = cfg.dst;
            RI_END:  rdata = cfg.dst_end;
            RI_BUS:  rdata = {27'b0, cfg.bus};
            RI_OPT:  rdata = {31'b0, cfg.fast};
            RI_OPD:  rdata = {24'b0, cfg.op_dual};
            default: rdata = {24'b0, cfg.op_quad};
        endcase
    end

    a_r10_frozen_src: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) && start |-> $stable(cfg.src));
endmodule

// File: rtl/nordma_flash_seq.sv
// Mode-0 serial flash read sequencer: opcode, address, dummy clocks, data.
// One flash clock spans two system clocks. The flash clock is held low
// at a byte boundary while can_accept is low. Assumes the configuration
// inputs stay stable from go until done.
module nordma_flash_seq
    import nordma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr4,
    input  lane_e             alanes,
    input  lane_e             dlanes,
    input  logic [3:0]        dummy_clks,
    input  logic [ADDR_W-1:0] nbytes,
    input  logic              can_accept,
    output logic              sclk,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in,
    output logic              byte_vld,
    output logic [7:0]        byte_data,
    output logic              done
);
    typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_END} st_e;

    st_e               st;
    lane_e             cur_ln;
    logic [ADDR_W-1:0] sh, sh_nxt;
    logic [5:0]        cnt;
    logic [3:0]        bclk;
    logic [ADDR_W-1:0] left;
    logic [7:0]        rx, rx_nxt;
    logic [3:0]        cpb;
    logic [5:0]        aclk;
    logic [3:0]        amask;
    logic              at_byte_start;

    assign cpb           = 4'd8 >> dlanes;
    assign aclk          = (addr4 ? 6'd32 : 6'd24) >> alanes;
    assign at_byte_start = (bclk == cpb);

    // Output line mask and shift step for the current transmit width.
    always_comb begin
        unique case (alanes)
            LN_2:    amask = 4'b0011;
            LN_4:    amask = 4'b1111;
            default: amask = 4'b0001;
        endcase
        unique case (cur_ln)
            LN_2:    begin io_out = {2'b0, sh[ADDR_W-1 -: 2]}; sh_nxt = sh << 2; end
            LN_4:    begin io_out = sh[ADDR_W-1 -: 4];         sh_nxt = sh << 4; end
            default: begin io_out = {3'b0, sh[ADDR_W-1]};      sh_nxt = sh << 1; end
        endcase
    end

    // Receive shift: gather the sampled lines into the byte in progress.
    always_comb begin
        unique case (dlanes)
            LN_2:    rx_nxt = {rx[5:0], io_in[1:0]};
            LN_4:    rx_nxt = {rx[3:0], io_in};
            default: rx_nxt = {rx[6:0], io_in[1]};
        endcase
    end

    // Phase sequencer and flash clock generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            cur_ln    <= LN_1;
            sh        <= '0;
            cnt       <= '0;
            bclk      <= '0;
            left      <= '0;
            rx        <= '0;
            sclk      <= 1'b0;
            cs_n      <= 1'b1;
            io_oe     <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
            done      <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            done     <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    sclk <= 1'b0;
                    if (go) begin
                        st     <= S_CMD;
                        cs_n   <= 1'b0;
                        sh     <= {opcode, {(ADDR_W-8){1'b0}}};
                        cnt    <= 6'd8;
                        cur_ln <= LN_1;
                        io_oe  <= 4'b0001;
                        left   <= nbytes;
                    end
                end
                S_CMD, S_ADDR, S_DUMMY: begin
                    sclk <= !sclk;
                    if (sclk) begin
                        if (cnt != 6'd1) begin
                            cnt <= cnt - 6'd1;
                            sh  <= sh_nxt;
                        end else if (st == S_CMD) begin
                            st     <= S_ADDR;
                            sh     <= addr4 ? addr : {addr[23:0], 8'h00};
                            cur_ln <= alanes;
                            cnt    <= aclk;
                            io_oe  <= amask;
                        end else if (st == S_ADDR && dummy_clks != 4'd0) begin
                            st    <= S_DUMMY;
                            cnt   <= {2'b0, dummy_clks};
                            io_oe <= '0;
                        end else begin
                            st    <= S_DATA;
                            bclk  <= cpb;
                            io_oe <= '0;
                        end
                    end
                end
                S_DATA: begin
                    if (!sclk) begin
                        if (!(at_byte_start && !can_accept)) begin
                            sclk <= 1'b1;
                            rx   <= rx_nxt;
                            if (bclk == 4'd1) begin
                                byte_vld  <= 1'b1;
                                byte_data <= rx_nxt;
                                left      <= left - 1'b1;
                                bclk      <= cpb;
                            end else begin
                                bclk <= bclk - 4'd1;
                            end
                        end
                    end else begin
                        sclk <= 1'b0;
                        if (left == '0) begin
                            st   <= S_END;
                            cs_n <= 1'b1;
                        end
                    end
                end
                default: begin
                    done <= 1'b1;
                    st   <= S_IDLE;
                end
            endcase
        end
    end

    a_r1_clk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    a_r3_cmd_on_line0: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CMD) |-> (io_oe == 4'b0001));
    a_r8_stall_holds_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DATA) && !sclk && at_byte_start && !can_accept |=> !sclk);
endmodule

// File: rtl/nordma_line_pack.sv
// Packs received bytes into lines and issues one write request per line.
// A line holding area and an output slot give one line of slack.
// Assumes the producer pushes only while can_accept is high.
module nordma_line_pack
    import nordma_pkg::*;
#(
    parameter int LINE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       base,
    input  logic                    byte_vld,
    input  logic [7:0]              byte_data,
    output logic                    can_accept,
    output logic                    empty,
    output logic                    mw_valid,
    input  logic                    mw_ready,
    output logic [ADDR_W-1:0]       mw_addr,
    output logic [8*LINE_BYTES-1:0] mw_data
);
    localparam int FILL_W = $clog2(LINE_BYTES + 1);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(LINE_BYTES);

    logic [FILL_W-1:0]       fill;
    logic [8*LINE_BYTES-1:0] line_q;
    logic [ADDR_W-1:0]       nxt_addr;
    logic                    move;

    assign move       = (fill == FULL) && (!mw_valid || mw_ready);
    assign can_accept = (fill != FULL);
    assign empty      = (fill == '0) && !mw_valid;

    // Byte gathering and hand-off of full lines to the request slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill     <= '0;
            line_q   <= '0;
            nxt_addr <= '0;
            mw_valid <= 1'b0;
            mw_addr  <= '0;
            mw_data  <= '0;
        end else begin
            if (load)
                nxt_addr <= base;
            if (byte_vld) begin
                line_q[{fill[OFS_W-1:0], 3'b000} +: 8] <= byte_data;
                fill <= fill + 1'b1;
            end
            if (move) begin
                mw_valid <= 1'b1;
                mw_addr  <= nxt_addr;
                mw_data  <= line_q;
                nxt_addr <= nxt_addr + ADDR_W'(LINE_BYTES);
                fill     <= '0;
            end else if (mw_valid && mw_ready) begin
                mw_valid <= 1'b0;
            end
        end
    end

    a_r8_request_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));
    a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> fill < FULL);
    a_r7_aligned_request: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid |-> mw_addr[OFS_W-1:0] == '0);
endmodule

// File: rtl/nor_dma_reader.sv
// Flash-to-memory DMA read engine top level.
// Decodes the bus mode into opcode, lane counts and dummy clocks,
// launches the sequencer, and clears the start bit once every line has
// been written. Assumes software programs aligned addresses and lengths.
module nor_dma_reader
    import nordma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_idx,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          spi_sclk,
    output logic          spi_cs_n,
    output logic [3:0]    spi_io_out,
    output logic [3:0]    spi_io_oe,
    input  logic [3:0]    spi_io_in,
    output logic          mw_valid,
    input  logic          mw_ready,
    output logic [31:0]   mw_addr,
    output logic [127:0]  mw_data
);
    localparam int LINE_BYTES = 16;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LINE_BYTES - 1);

    typedef enum logic [1:0] {T_IDLE, T_RUN, T_DRAIN, T_FIN} top_e;

    cfg_t              cfg;
    logic              start, clr_start, go;
    top_e              tst;
    logic              quad, dual;
    lane_e             alanes, dlanes;
    logic [7:0]        opcode;
    logic [3:0]        dummy;
    logic [ADDR_W-1:0] nbytes;
    logic              can_accept, empty, byte_vld, seq_done;
    logic [7:0]        byte_data;

    nordma_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
        .clr_start(clr_start), .rdata(reg_rdata), .start(start), .cfg(cfg)
    );

    // Mode decode: quad wins over dual; single picks opcode from fast bit.
    always_comb begin
        quad   = cfg.bus[2];
        dual   = cfg.bus[0] && !quad;
        dlanes = quad ? LN_4 : (dual ? LN_2 : LN_1);
        alanes = (quad && cfg.bus[3]) ? LN_4 : ((dual && cfg.bus[1]) ? LN_2 : LN_1);
        opcode = quad ? cfg.op_quad : (dual ? cfg.op_dual : (cfg.fast ? 8'h0B : 8'h03));
        dummy  = (quad || dual || cfg.fast) ? 4'd8 : 4'd0;
        nbytes = (cfg.dst_end - cfg.dst) & ALIGN_MASK;
    end

    // Transfer control: launch, wait for the sequencer, drain, clear start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tst       <= T_IDLE;
            go        <= 1'b0;
            clr_start <= 1'b0;
        end else begin
            go        <= 1'b0;
            clr_start <= 1'b0;
            unique case (tst)
                T_IDLE: if (start) begin
                    if (nbytes == '0) begin
                        clr_start <= 1'b1;
                        tst       <= T_FIN;
                    end else begin
                        go  <= 1'b1;
                        tst <= T_RUN;
                    end
                end
                T_RUN:   if (seq_done) tst <= T_DRAIN;
                T_DRAIN: if (empty) begin
                    clr_start <= 1'b1;
                    tst       <= T_FIN;
                end
                default: tst <= T_IDLE;
            endcase
        end
    end

    nordma_flash_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .opcode(opcode),
        .addr(cfg.src & ALIGN_MASK), .addr4(cfg.bus[4]),
        .alanes(alanes), .dlanes(dlanes), .dummy_clks(dummy), .nbytes(nbytes),
        .can_accept(can_accept), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .io_out(spi_io_out), .io_oe(spi_io_oe), .io_in(spi_io_in),
        .byte_vld(byte_vld), .byte_data(byte_data), .done(seq_done)
    );

    nordma_line_pack #(.LINE_BYTES(LINE_BYTES)) u_pack (
        .clk(clk), .rst_n(rst_n), .load(go), .base(cfg.dst & ALIGN_MASK),
        .byte_vld(byte_vld), .byte_data(byte_data), .can_accept(can_accept),
        .empty(empty), .mw_valid(mw_valid), .mw_ready(mw_ready),
        .mw_addr(mw_addr), .mw_data(mw_data)
    );

    a_r9_clear_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start) |-> spi_cs_n && !mw_valid);
    a_r9_deselected_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> spi_cs_n);
endmodule

// File: tb/nor_dma_reader_bench.sv
module nor_dma_reader_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_idx = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         spi_sclk, spi_cs_n;
    logic [3:0]   spi_io_out, spi_io_oe;
    logic [3:0]   spi_io_in = '0;
    logic         mw_valid;
    logic         mw_ready = 1'b1;
    logic [31:0]  mw_addr;
    logic [127:0] mw_data;

    int checks = 0, errors = 0, cyc = 0;

    always #5 clk = ~clk;

    nor_dma_reader u_nor_dma_reader (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
        .spi_io_in(spi_io_in), .mw_valid(mw_valid), .mw_ready(mw_ready),
        .mw_addr(mw_addr), .mw_data(mw_data)
    );

    function automatic logic [7:0] fb(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            summary();
        end
    end

    // Flash model parameters, set per transfer.
    int m_al = 1, m_dl = 1, m_dum = 0, m_abits = 24;
    int m_n = 0;
    int cs_falls = 0, sclk_rises = 0;
    logic [7:0]  m_op = '0;
    logic [31:0] m_addr = '0;

    // Capture opcode and address on rising clock; reset on select.
    always @(posedge spi_sclk or negedge spi_cs_n) begin
        if (spi_sclk) begin
            sclk_rises++;
            if (m_n < 8)
                m_op <= {m_op[6:0], spi_io_out[0]};
            else if (m_n < 8 + m_abits / m_al)
                m_addr <= (m_addr << m_al) | 32'(spi_io_out & 4'((1 << m_al) - 1));
            m_n <= m_n + 1;
        end else begin
            cs_falls++;
            m_n    <= 0;
            m_op   <= '0;
            m_addr <= '0;
        end
    end

    // Drive read data on falling clock.
    always @(negedge spi_sclk) begin
        int d, cpb, bi, pos;
        logic [7:0] b, v;
        d = m_n - (8 + m_abits / m_al + m_dum);
        if (d >= 0) begin
            cpb = 8 / m_dl;
            bi  = d / cpb;
            pos = d % cpb;
            b   = fb(m_addr + 32'(bi));
            v   = b >> (8 - m_dl * (pos + 1));
            case (m_dl)
                1:       spi_io_in <= {2'b0, v[0], 1'b0};
                2:       spi_io_in <= {2'b0, v[1:0]};
                default: spi_io_in <= v[3:0];
            endcase
        end
    end

    // Memory model: ready pattern and captured writes.
    int rdy_mode = 0;
    int nlines = 0, stab_err = 0;
    logic [31:0]  cap_addr [0:63];
    logic [127:0] cap_data [0:63];
    logic         p_wait = 1'b0;
    logic [31:0]  p_addr = '0;
    logic [127:0] p_data = '0;

    always @(negedge clk)
        mw_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (cyc % 7 == 0) : 1'b0;

    always @(posedge clk) begin
        if (p_wait && !(mw_valid && mw_addr == p_addr && mw_data == p_data))
            stab_err++;
        p_wait <= mw_valid && !mw_ready;
        p_addr <= mw_addr;
        p_data <= mw_data;
        if (mw_valid && mw_ready) begin
            if (nlines < 64) begin
                cap_addr[nlines] = mw_addr;
                cap_data[nlines] = mw_data;
            end
            nlines++;
        end
    end

    task automatic reg_write(input logic [2:0] i, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] i, output logic [31:0] d);
        @(negedge clk);
        reg_idx = i;
        #1 d = reg_rdata;
    endtask

    logic [31:0] x_addr, x_dst;
    int          x_lines;

    task automatic start_xfer(input logic [31:0] src, dst, dend, input logic [4:0] bus,
                              input bit fast, input logic [7:0] opd, opq,
                              input int al, dl, dum, abits);
        reg_write(3'd1, src);
        reg_write(3'd2, dst);
        reg_write(3'd3, dend);
        reg_write(3'd4, {27'b0, bus});
        reg_write(3'd5, {31'b0, fast});
        reg_write(3'd6, {24'b0, opd});
        reg_write(3'd7, {24'b0, opq});
        m_al = al; m_dl = dl; m_dum = dum; m_abits = abits;
        x_addr  = (abits == 32) ? (src & ~32'hF) : ((src & ~32'hF) & 32'h00FF_FFFF);
        x_dst   = dst & ~32'hF;
        x_lines = int'((dend - dst) >> 4);
        nlines = 0; stab_err = 0;
        reg_write(3'd0, 32'h1);
    endtask

    task automatic finish_xfer(input string req, input logic [7:0] exp_op);
        logic [31:0]  v;
        logic [127:0] e;
        bit           ok = 1'b1;
        int           bad = -1;
        v = 32'h1;
        for (int k = 0; k < 20000 && v[0]; k++) reg_read(3'd0, v);
        chk(v[0] == 1'b0, "R9", {req, " start bit cleared"}, v, 0);
        chk(spi_cs_n == 1'b1, "R9", {req, " deselected at completion"}, spi_cs_n, 1);
        chk(nlines == x_lines, "R7", {req, " line count"}, nlines, x_lines);
        chk(m_op == exp_op, req, "opcode", m_op, exp_op);
        chk(m_addr == x_addr, "R4", {req, " flash address"}, m_addr, x_addr);
        for (int l = 0; l < x_lines && l < nlines; l++) begin
            for (int j = 0; j < 16; j++) e[8*j +: 8] = fb(x_addr + 32'(16*l + j));
            if (ok && (cap_data[l] != e || cap_addr[l] != x_dst + 32'(16*l))) begin
                ok = 1'b0; bad = l;
            end
        end
        if (bad >= 0) begin
            for (int j = 0; j < 16; j++) e[8*j +: 8] = fb(x_addr + 32'(16*bad + j));
            chk(1'b0, "R7", {req, " line data"}, cap_data[bad], e);
        end else begin
            chk(1'b1, "R7", {req, " line data"}, 0, 0);
        end
        chk(stab_err == 0, "R8", {req, " request stable while waiting"}, stab_err, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            reg_read(3'(i), v);
            chk(v == 0, "R1", "register after reset", v, 0);
        end
        chk(spi_cs_n && !spi_sclk && !mw_valid, "R1", "port idle after reset",
            {spi_cs_n, spi_sclk, mw_valid}, 3'b100);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        reg_write(3'd1, 32'hCAFE_1234); reg_read(3'd1, v); chk(v == 32'hCAFE_1234, "R2", "source", v, 32'hCAFE_1234);
        reg_write(3'd2, 32'h1111_2220); reg_read(3'd2, v); chk(v == 32'h1111_2220, "R2", "dest start", v, 32'h1111_2220);
        reg_write(3'd3, 32'h1111_2220); reg_read(3'd3, v); chk(v == 32'h1111_2220, "R2", "dest end", v, 32'h1111_2220);
        reg_write(3'd4, 32'hFFFF_FFFF); reg_read(3'd4, v); chk(v == 32'h1F, "R2", "bus mode", v, 32'h1F);
        reg_write(3'd5, 32'hFFFF_FFFF); reg_read(3'd5, v); chk(v == 32'h1, "R2", "options", v, 1);
        reg_write(3'd6, 32'h1234_56BB); reg_read(3'd6, v); chk(v == 32'hBB, "R2", "dual opcode", v, 32'hBB);
        reg_write(3'd7, 32'h1234_56EB); reg_read(3'd7, v); chk(v == 32'hEB, "R2", "quad opcode", v, 32'hEB);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int f0;
        f0 = cs_falls;
        start_xfer(32'h100, 32'h2000, 32'h2000, 5'h0, 1'b0, 8'h0, 8'h0, 1, 1, 0, 24);
        repeat (10) @(negedge clk);
        reg_read(3'd0, v);
        chk(v[0] == 1'b0, "R9", "zero length completes", v, 0);
        chk(cs_falls == f0 && nlines == 0, "R9", "zero length no access",
            {cs_falls - f0, nlines}, 0);
    endtask

    task automatic t_stall();
        int r0;
        rdy_mode = 2;
        start_xfer(32'h0000_4000, 32'h3000, 32'h3040, 5'h0, 1'b0, 8'h0, 8'h0, 1, 1, 0, 24);
        repeat (3000) @(negedge clk);
        r0 = sclk_rises;
        repeat (200) @(negedge clk);
        chk(sclk_rises == r0, "R8", "flash clock stopped while full", sclk_rises - r0, 0);
        chk(spi_cs_n == 1'b0 && nlines == 0, "R8", "held transfer pending",
            {spi_cs_n, nlines[7:0]}, 0);
        rdy_mode = 1;
        finish_xfer("R8 stall", 8'h03);
        rdy_mode = 0;
    endtask

    task automatic t_busy();
        logic [31:0] v;
        start_xfer(32'h0000_8000, 32'h5000, 32'h5020, 5'h0, 1'b1, 8'h0, 8'h0, 1, 1, 8, 24);
        repeat (60) @(negedge clk);
        reg_write(3'd1, 32'hDEAD_0000);
        reg_write(3'd0, 32'h0);
        reg_read(3'd1, v);
        chk(v == 32'h0000_8000, "R10", "source write ignored while busy", v, 32'h8000);
        reg_read(3'd0, v);
        chk(v[0] == 1'b1, "R10", "control write ignored while busy", v, 1);
        finish_xfer("R10 busy", 8'h0B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        // R3 R4: single line, plain read, 24-bit address
        start_xfer(32'h0001_2340, 32'h1000, 32'h1020, 5'h00, 1'b0, 8'h0, 8'h0, 1, 1, 0, 24);
        finish_xfer("R3 plain", 8'h03);
        // R3 R4: fast read, 4-byte address, non-multiple length (R7)
        start_xfer(32'h1234_5670, 32'h2010, 32'h2038, 5'h10, 1'b1, 8'h0, 8'h0, 1, 1, 8, 32);
        finish_xfer("R3 fast", 8'h0B);
        // R5: dual data, dual address
        start_xfer(32'h0000_A5A0, 32'h4000, 32'h4030, 5'h03, 1'b0, 8'hBB, 8'h0, 2, 2, 8, 24);
        finish_xfer("R5 dual", 8'hBB);
        // R5: dual data, single address
        start_xfer(32'h0000_1100, 32'h4100, 32'h4110, 5'h01, 1'b0, 8'h3B, 8'h0, 1, 2, 8, 24);
        finish_xfer("R5 dual-out", 8'h3B);
        // R6: quad over dual, quad address, unaligned source (R4)
        start_xfer(32'h0123_4567, 32'h6000, 32'h6040, 5'h0D, 1'b0, 8'hBB, 8'hEB, 4, 4, 8, 24);
        finish_xfer("R6 quad", 8'hEB);
        t_stall();
        t_busy();
        t_zero();
        summary();
    end
endmodule